// File: doc/BRIEF.md
# Banked Nibble Control-Register Port

This block is the host-side register access logic of a display controller. A host drives an 8-bit bus together with chip-select, register-select, write-strobe and read-strobe lines. When register-select is high, every byte written is one complete register access. The high four bits name a slot and the low four bits are the value for that slot. When register-select is low, the access is meant for display memory. In that case the block only forwards a memory write pulse or a memory read strobe and does not change its own state.

The sixteen slots of a page are organised as follows. Slots 0 to 13 form seven pairs. In each pair the even slot holds the low nibble and the odd slot holds the high nibble of an 8-bit value. A bank pointer picks which of several pages of pairs the host is addressing. Slot 15 sets the bank pointer and slot 14 sets the read pointer. Both slots work the same way in every page, so the host can always change page.

A low nibble written to a pair goes only into a shadow register. The 8-bit value changes only when the high nibble arrives, so the rest of the chip never sees a half-written value. A read returns the nibble at the slot named by the read pointer, in the current page.

Top module: `nbr_regif`

## Requirements
- R1: While rst_n is low, and after it rises with no write since, the bank pointer and the read pointer are 0. The 8-bit value of pair p in bank b is 0 for bank 0 and (7*b + 11*p) mod 32 for any other bank. Each pair's shadow holds the low nibble of that reset value.
- R2: A register write to an even slot s < 14 updates only the shadow of pair s/2 in the current bank. The visible 8-bit value of that pair does not change.
- R3: A register write to an odd slot s < 14 sets pair s/2 in the current bank to {written nibble, shadow}. Pairs in other banks and other pairs stay unchanged.
- R4: A register write to slot 15 with value v sets the bank pointer to v only when v < NBANK (6 by default). A larger value is ignored. The bank pointer is always below NBANK.
- R5: A register write to slot 14 with value v sets the read pointer to v.
- R6: While cs_n, rd_n are low and rs is high, dout_oe is 1 and dout = {read pointer, nibble}. The nibble depends on the read pointer. For pointer 15 it is the bank pointer. For pointer 14 it is the read pointer itself. For any other pointer it is the low nibble (even pointer) or the high nibble (odd pointer) of pair pointer/2 in the current bank. In every other case dout_oe is 0 and dout is 0.
- R7: A write takes effect on the first clock edge at which wr_n is sampled high after being sampled low on the previous edge, provided cs_n is low at that edge. No state changes at any other edge.
- R8: With rs low, a completed write raises ram_wr for exactly one cycle (from the wr_n rise to the next edge) and changes no register. ram_rd equals the AND of the active cs_n, the active rd_n and a low rs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | 1 = control registers, 0 = display memory |
| wr_n | input | 1 | Write strobe, active low; write completes on its rise |
| rd_n | input | 1 | Read strobe, active low |
| din | input | 8 | Host write byte: [7:4] slot, [3:0] value |
| dout | output | 8 | Read byte: [7:4] read pointer, [3:0] data |
| dout_oe | output | 1 | Read data valid / bus drive enable |
| ram_wr | output | 1 | One-cycle display-memory write pulse |
| ram_rd | output | 1 | Display-memory read strobe |
| bank_sel | output | BANK_W | Current bank pointer |
| pair_flat | output | NBANK*7*8 | Committed 8-bit pair values, pair p of bank b at bits (b*7+p)*8 |

## Verification
A register or memory write is due at the clock edge that follows the negedge at which the bench raises wr_n. This is the second edge after the strobe fell, because one register stage watches wr_n. The bench therefore checks committed values at the negedge after that edge. In the high-nibble timing case it also checks at the negedge just before that edge, where the old value must still be present. Reads and ram_rd are combinational, so they are sampled 2 ns after the strobes are driven. The ram_wr pulse is sampled inside its single cycle and again one negedge later.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam int NIB_W  = 4;
  localparam int PAIR_W = 2 * NIB_W;
  localparam int NPAIR  = 7;
  localparam logic [3:0] SLOT_PTR  = 4'd14;
  localparam logic [3:0] SLOT_BANK = 4'd15;

  // Reset content of pair p in bank b (5-bit values, bank 0 cleared)
  function automatic logic [PAIR_W-1:0] pair_reset(input int b, input int p);
    if (b == 0) return '0;
    return PAIR_W'((b * 7 + p * 11) % 32);
  endfunction

  function automatic logic [NIB_W-1:0] pick_nibble(input logic [PAIR_W-1:0] pair,
                                                   input logic upper);
    return upper ? pair[PAIR_W-1:NIB_W] : pair[NIB_W-1:0];
  endfunction

  function automatic logic bank_ok(input logic [NIB_W-1:0] v, input int nbank);
    return int'(v) < nbank;
  endfunction
endpackage

// File: rtl/nbr_strobe.sv
module nbr_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rs,
  input  logic wr_n,
  output logic reg_wr_evt,
  output logic ram_wr_evt
);
  logic wr_n_q;
  logic wr_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_n_q <= 1'b1;
    else        wr_n_q <= wr_n;
  end

  assign wr_rise    = wr_n & ~wr_n_q & ~cs_n;
  assign reg_wr_evt = wr_rise & rs;
  assign ram_wr_evt = wr_rise & ~rs;
endmodule

// File: rtl/nbr_ctrl.sv
module nbr_ctrl #(
  parameter int NBANK  = 6,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_evt,
  input  logic              ptr_evt,
  input  logic [3:0]        wval,
  output logic [BANK_W-1:0] bank_sel,
  output logic [3:0]        rd_ptr
);
  import nbr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_sel <= '0;
      rd_ptr   <= '0;
    end else begin
      if (bank_evt && bank_ok(wval, NBANK)) bank_sel <= wval[BANK_W-1:0];
      if (ptr_evt) rd_ptr <= wval;
    end
  end
endmodule

// File: rtl/nbr_bank_file.sv
module nbr_bank_file #(
  parameter int NBANK  = 6,
  parameter int BANK_W = 3
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     lo_evt,
  input  logic                                     hi_evt,
  input  logic [BANK_W-1:0]                        bank_sel,
  input  logic [2:0]                               pair_idx,
  input  logic [3:0]                               wval,
  output logic [NBANK*nbr_pkg::NPAIR*nbr_pkg::PAIR_W-1:0] pair_flat
);
  import nbr_pkg::*;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      localparam logic [PAIR_W-1:0] RV = pair_reset(b, p);
      logic             hit;
      logic [NIB_W-1:0] shadow_q;
      logic [PAIR_W-1:0] val_q;

      assign hit = (bank_sel == BANK_W'(b)) && (pair_idx == 3'(p));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow_q <= RV[NIB_W-1:0];
          val_q    <= RV;
        end else begin
          if (lo_evt && hit) shadow_q <= wval;
          if (hi_evt && hit) val_q    <= {wval, shadow_q};
        end
      end

      assign pair_flat[(b*NPAIR+p)*PAIR_W +: PAIR_W] = val_q;
    end
  end
endmodule

// File: rtl/nbr_readmux.sv
module nbr_readmux #(
  parameter int NBANK  = 6,
  parameter int BANK_W = 3
) (
  input  logic                                     cs_n,
  input  logic                                     rs,
  input  logic                                     rd_n,
  input  logic [NBANK*nbr_pkg::NPAIR*nbr_pkg::PAIR_W-1:0] pair_flat,
  input  logic [BANK_W-1:0]                        bank_sel,
  input  logic [3:0]                               rd_ptr,
  output logic [7:0]                               dout,
  output logic                                     dout_oe
);
  import nbr_pkg::*;

  logic [NIB_W-1:0]  nib;
  logic [PAIR_W-1:0] cur_pair;
  int                idx;

  always_comb begin
    idx      = int'(bank_sel) * NPAIR + int'(rd_ptr[3:1]);
    cur_pair = '0;
    if (rd_ptr[3:1] != 3'd7 && idx < NBANK * NPAIR)
      cur_pair = pair_flat[idx*PAIR_W +: PAIR_W];
    if (rd_ptr == SLOT_BANK)     nib = NIB_W'(bank_sel);
    else if (rd_ptr == SLOT_PTR) nib = rd_ptr;
    else                         nib = pick_nibble(cur_pair, rd_ptr[0]);
    dout_oe = !cs_n && rs && !rd_n;
    dout    = dout_oe ? {rd_ptr, nib} : 8'h00;
  end
endmodule

// File: rtl/nbr_regif.sv
module nbr_regif #(
  parameter int NBANK  = 6,
  parameter int BANK_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          rs,
  input  logic                          wr_n,
  input  logic                          rd_n,
  input  logic [7:0]                    din,
  output logic [7:0]                    dout,
  output logic                          dout_oe,
  output logic                          ram_wr,
  output logic                          ram_rd,
  output logic [BANK_W-1:0]             bank_sel,
  output logic [NBANK*7*8-1:0]          pair_flat
);
  import nbr_pkg::*;

  logic       reg_wr_evt;
  logic       lo_evt;
  logic       hi_evt;
  logic       ptr_evt;
  logic       bank_evt;
  logic [3:0] wr_slot;
  logic [3:0] wr_val;
  logic [3:0] rd_ptr;

  assign wr_slot  = din[7:4];
  assign wr_val   = din[3:0];
  assign lo_evt   = reg_wr_evt && (wr_slot < SLOT_PTR) && !wr_slot[0];
  assign hi_evt   = reg_wr_evt && (wr_slot < SLOT_PTR) &&  wr_slot[0];
  assign ptr_evt  = reg_wr_evt && (wr_slot == SLOT_PTR);
  assign bank_evt = reg_wr_evt && (wr_slot == SLOT_BANK);
  assign ram_rd   = !cs_n && !rs && !rd_n;

  nbr_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .wr_n(wr_n),
    .reg_wr_evt(reg_wr_evt), .ram_wr_evt(ram_wr)
  );

  nbr_ctrl #(.NBANK(NBANK), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bank_evt(bank_evt), .ptr_evt(ptr_evt),
    .wval(wr_val), .bank_sel(bank_sel), .rd_ptr(rd_ptr)
  );

  nbr_bank_file #(.NBANK(NBANK), .BANK_W(BANK_W)) u_file (
    .clk(clk), .rst_n(rst_n), .lo_evt(lo_evt), .hi_evt(hi_evt),
    .bank_sel(bank_sel), .pair_idx(wr_slot[3:1]), .wval(wr_val),
    .pair_flat(pair_flat)
  );

  nbr_readmux #(.NBANK(NBANK), .BANK_W(BANK_W)) u_rd (
    .cs_n(cs_n), .rs(rs), .rd_n(rd_n), .pair_flat(pair_flat),
    .bank_sel(bank_sel), .rd_ptr(rd_ptr), .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/nbr_regif_chk.sv
module nbr_regif_chk #(
  parameter int NBANK  = 6,
  parameter int BANK_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic [7:0]           dout,
  input logic                 dout_oe,
  input logic                 ram_wr,
  input logic [BANK_W-1:0]    bank_sel,
  input logic [NBANK*56-1:0]  pair_flat,
  input logic                 reg_wr_evt,
  input logic                 lo_evt,
  input logic                 bank_evt
);
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(bank_sel) < NBANK); // R4
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bank_evt |=> $stable(bank_sel)); // R4
  AST_LOWER_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) lo_evt |=> $stable(pair_flat)); // R2
  AST_FLAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !reg_wr_evt |=> $stable(pair_flat)); // R7
  AST_CS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !reg_wr_evt && !ram_wr); // R7
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !dout_oe |-> dout == 8'h00); // R6
  AST_RAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ram_wr && reg_wr_evt)); // R8
  AST_RAM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ram_wr |=> !ram_wr); // R8
endmodule

bind nbr_regif nbr_regif_chk #(.NBANK(NBANK), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout), .dout_oe(dout_oe),
  .ram_wr(ram_wr), .bank_sel(bank_sel), .pair_flat(pair_flat),
  .reg_wr_evt(reg_wr_evt), .lo_evt(lo_evt), .bank_evt(bank_evt)
);

// File: tb/nbr_regif_test.sv
module nbr_regif_test;
  localparam int NB = 6;
  localparam int NP = 7;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rs = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic dout_oe, ram_wr, ram_rd;
  logic [2:0] bank_sel;
  logic [NB*NP*8-1:0] pair_flat;

  int checks = 0, errors = 0;
  logic [7:0] em [NB][NP];
  logic [3:0] sh [NB][NP];
  int bank = 0;
  logic [3:0] ptr = 4'h0;

  always #10 clk = ~clk;

  nbr_regif uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .wr_n(wr_n),
    .rd_n(rd_n), .din(din), .dout(dout), .dout_oe(dout_oe), .ram_wr(ram_wr),
    .ram_rd(ram_rd), .bank_sel(bank_sel), .pair_flat(pair_flat));

  task automatic check(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < NP; p++) begin
        em[b][p] = (b == 0) ? 8'h00 : 8'((7 * b + 11 * p) % 32);
        sh[b][p] = em[b][p][3:0];
      end
    bank = 0;
    ptr = 4'h0;
  endtask

  function automatic logic [NB*NP*8-1:0] exp_flat();
    logic [NB*NP*8-1:0] e;
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < NP; p++) e[(b*NP+p)*8 +: 8] = em[b][p];
    return e;
  endfunction

  task automatic model_write(input logic [7:0] d);
    int a = int'(d[7:4]);
    if (a < 14) begin
      if (a % 2 == 0) sh[bank][a/2] = d[3:0];
      else em[bank][a/2] = {d[3:0], sh[bank][a/2]};
    end else if (a == 14) ptr = d[3:0];
    else if (int'(d[3:0]) < NB) bank = int'(d[3:0]);
  endtask

  task automatic bus_write(input logic rsel, input logic csn, input logic [7:0] d);
    @(negedge clk); cs_n = csn; rs = rsel; din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; rs = 1'b1;
  endtask

  task automatic reg_wr(input logic [7:0] d);
    bus_write(1'b1, 1'b0, d);
    model_write(d);
  endtask

  task automatic check_flat(input string tag);
    check(pair_flat === exp_flat(), tag, 512'(pair_flat), 512'(exp_flat()));
  endtask

  task automatic rd_check(input string tag);
    logic [3:0] nib;
    if (ptr == 4'd15) nib = 4'(bank);
    else if (ptr == 4'd14) nib = ptr;
    else nib = ptr[0] ? em[bank][ptr/2][7:4] : em[bank][ptr/2][3:0];
    @(negedge clk); cs_n = 1'b0; rs = 1'b1; rd_n = 1'b0;
    #2;
    check(dout === {ptr, nib} && dout_oe === 1'b1, tag, 512'(dout), 512'({ptr, nib}));
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic readback_all(input string tag);
    for (int b = 0; b < NB; b++) begin
      reg_wr({4'hF, 4'(b)});
      for (int s = 0; s < 14; s++) begin
        reg_wr({4'hE, 4'(s)});
        rd_check(tag);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state during and after reset
    check(bank_sel === 3'd0, "R1 bank in reset", 512'(bank_sel), 0);
    check_flat("R1 pairs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_flat("R1 pairs after reset");
    check(dout_oe === 1'b0 && dout === 8'h00, "R6 idle bus", 512'(dout), 0);
    readback_all("R1 R6 reset readback");

    // R2 then R3 in bank 2, pair 3
    reg_wr(8'hF2);
    reg_wr(8'h6A);
    check_flat("R2 lower write held in shadow");
    reg_wr(8'hE6);
    rd_check("R2 readback of lower slot before commit");
    // R7 timing of the upper write
    @(negedge clk); cs_n = 1'b0; rs = 1'b1; din = 8'h75; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    check_flat("R7 no commit before wr_n rise is sampled");
    @(negedge clk); cs_n = 1'b1;
    model_write(8'h75);
    check(em[2][3] === 8'h5A, "R3 model pair", 512'(em[2][3]), 512'(8'h5A));
    check_flat("R3 upper write commits pair");

    // R3 sweep: every pair of every bank
    for (int b = 0; b < NB; b++) begin
      reg_wr({4'hF, 4'(b)});
      for (int p = 0; p < NP; p++) begin
        reg_wr({4'(2*p), 4'((b + p) % 16)});
        check_flat("R2 sweep lower");
        reg_wr({4'(2*p+1), 4'((3*b + p + 1) % 16)});
        check_flat("R3 sweep upper");
      end
    end
    readback_all("R3 R6 sweep readback");

    // R4 bank select limits
    reg_wr(8'hF5);
    check(bank_sel === 3'd5, "R4 bank 5", 512'(bank_sel), 5);
    reg_wr(8'hF6);
    check(bank_sel === 3'd5, "R4 bank 6 ignored", 512'(bank_sel), 5);
    reg_wr(8'hFF);
    check(bank_sel === 3'd5, "R4 bank 15 ignored", 512'(bank_sel), 5);
    reg_wr(8'hF0);
    check(bank_sel === 3'd0, "R4 bank 0 from bank 5", 512'(bank_sel), 0);

    // R5 read pointer on special slots
    reg_wr(8'hE0); reg_wr(8'hF4); reg_wr(8'hEF);
    rd_check("R5 R6 read of bank slot");
    reg_wr(8'hEE);
    rd_check("R5 R6 read of pointer slot");

    // R7 write with chip select high is ignored
    bus_write(1'b1, 1'b1, 8'h1F);
    check_flat("R7 cs_n high write ignored");
    bus_write(1'b1, 1'b1, 8'hF1);
    check(bank_sel === 3'd4, "R7 cs_n high bank write ignored", 512'(bank_sel), 4);

    // R8 display-memory access
    @(negedge clk); cs_n = 1'b0; rs = 1'b0; din = 8'h3C; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    #2 check(ram_wr === 1'b1, "R8 ram_wr pulse", 512'(ram_wr), 1);
    @(negedge clk);
    check(ram_wr === 1'b0, "R8 ram_wr single cycle", 512'(ram_wr), 0);
    cs_n = 1'b1; rs = 1'b1;
    check_flat("R8 memory write leaves registers");
    check(bank_sel === 3'd4, "R8 memory write leaves bank", 512'(bank_sel), 4);
    @(negedge clk); cs_n = 1'b0; rs = 1'b0; rd_n = 1'b0;
    #2 check(ram_rd === 1'b1, "R8 ram_rd active", 512'(ram_rd), 1);
    check(dout_oe === 1'b0 && dout === 8'h00, "R6 no register read when rs low", 512'(dout), 0);
    cs_n = 1'b1;
    #2 check(ram_rd === 1'b0, "R8 ram_rd needs cs", 512'(ram_rd), 0);
    rd_n = 1'b1; rs = 1'b1;
    @(negedge clk); rd_n = 1'b0;
    #2 check(dout_oe === 1'b0, "R6 no read with cs_n high", 512'(dout_oe), 0);
    rd_n = 1'b1;

    // R1 reset in the middle of operation
    @(negedge clk); rst_n = 1'b0;
    #2 model_reset();
    check_flat("R1 mid-run reset pairs");
    check(bank_sel === 3'd0, "R1 mid-run reset bank", 512'(bank_sel), 0);
    @(negedge clk); rst_n = 1'b1;
    reg_wr(8'hF3); reg_wr(8'h71);
    check_flat("R1 shadow restored by reset");

    summary();
    $finish;
  end
endmodule